// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of an 8-bit successive-approximation converter. A start pulse controls it through both of its edges. The rising edge clears the old result and raises the busy line. The falling edge launches a binary search that tries one bit at a time, starting at the most significant bit. While a bit is under trial, the block sets that bit in the code it presents to the internal DAC. It then reads the comparator and either keeps the bit or drops it before moving down one position. Busy falls once the least significant bit has been decided.

The result register is read through an active-low enable. The block drives an 8-bit value and a pad-enable signal, and a three-state pad cell outside the block uses them. The enable is not interlocked against a running conversion, so a read during the search returns the bits decided so far. The search does not depend on the coding. With a unipolar analog range the result is straight binary. With a bipolar range, where the DAC is offset by half scale, the same result reads as offset binary, with 0x80 at the midpoint.

Top module: `sarSequencer`

## Requirements
- R1: After reset, busy is low, the trial code and the result are zero, and the pad-enable is low.
- R2: A rising edge on the start input, sampled at a clock edge, raises busy and clears the result to zero at that same clock edge.
- R3: While the start input stays high after its rising edge, no search runs: the trial code stays zero and busy stays high.
- R4: On the clock edge that samples the falling edge of the start input, the trial code becomes 0x80, so the most significant bit is tried first.
- R5: Each bit decision takes BIT_CYCLES clocks. The comparator is sampled on the last of them. A comparator value of 1 (input at or above the trial level) keeps the bit. The trial then moves to the next lower bit.
- R6: Busy falls exactly 8*BIT_CYCLES clock edges after the edge that sampled the falling start edge. The result is then the largest code whose trial level the input reaches.
- R7: The pad-enable is high only while the data-enable input is low, and the data output then carries the result register.
- R8: A read during a conversion returns the partial result: the bits decided so far, with all undecided bits zero.
- R9: A rising start edge during a conversion aborts that conversion, clears the result and rearms the sequence. The following falling edge runs a complete fresh search.
- R10: After a conversion, the result holds its value until the next rising start edge.
- R11: With the DAC offset by half scale, the same search returns offset binary: input -128 gives 0x00, 0 gives 0x80, and -1 gives 0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Start pulse: the rising edge clears and arms, the falling edge launches the search |
| cmpIn | input | 1 | Comparator result, 1 when the input is at or above the trial level |
| dataEnN | input | 1 | Active-low read enable |
| trialCode | output | 8 | Code applied to the internal DAC |
| busyOut | output | 1 | High from the rising start edge until the last bit is decided |
| dataOut | output | 8 | Result register value for the pad cell |
| dataOe | output | 1 | Pad-enable for the three-state data pins |

## Verification
The search is run on all-zeros and all-ones inputs. These tell whether each comparator decision is applied to the correct bit or stuck. It is also run on the alternating patterns 0xA5 and 0x5A, which expose crossed or shifted bit positions, and on the 0x80 midpoint, which exercises the "at or above" tie. Bipolar inputs at the negative end, at zero and just below zero confirm the offset-binary reading. A mid-search read (0xA5 after four decisions) separates the partial result from the final one. A restart with a different input confirms that nothing from the aborted search carries over.

// File: rtl/sarSeqPkg.sv
package sarSeqPkg;
  typedef struct packed {
    logic clearAll;   // wipe result and trial mask
    logic beginSearch; // load MSB into trial mask
    logic decideBit;  // apply comparator, step mask down
  } sarStrobes_t;
endpackage

// File: rtl/sarControl.sv
module sarControl
  import sarSeqPkg::*;
#(
  parameter int BIT_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic        lastBit,
  output sarStrobes_t strb,
  output logic        busyOut
);
  localparam int CNT_W = $clog2(BIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BIT_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_CONV} seqState_t;

  seqState_t stateQ;
  logic [CNT_W-1:0] cntQ;
  logic startPrevQ;
  logic startRise, startFall;

  assign startRise = startIn && !startPrevQ;
  assign startFall = !startIn && startPrevQ;

  always_comb begin
    strb.clearAll    = startRise;
    strb.beginSearch = (stateQ == S_ARMED) && startFall;
    strb.decideBit   = (stateQ == S_CONV) && (cntQ == CNT_LAST) && !startRise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= S_IDLE;
      cntQ       <= '0;
      startPrevQ <= 1'b0;
    end else begin
      startPrevQ <= startIn;
      if (startRise) begin
        stateQ <= S_ARMED;
        cntQ   <= '0;
      end else if (strb.beginSearch) begin
        stateQ <= S_CONV;
        cntQ   <= '0;
      end else if (stateQ == S_CONV) begin
        if (strb.decideBit) begin
          cntQ <= '0;
          if (lastBit) stateQ <= S_IDLE;
        end else begin
          cntQ <= cntQ + 1'b1;
        end
      end
    end
  end

  assign busyOut = (stateQ != S_IDLE);

  // R2
  busy_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    startRise |=> busyOut);

  // R3
  hold_armed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_ARMED && startIn) |=> (stateQ == S_ARMED));

  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyOut) |-> $past(strb.decideBit && lastBit));
endmodule

// File: rtl/sarDatapath.sv
module sarDatapath
  import sarSeqPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  sarStrobes_t      strb,
  input  logic             cmpIn,
  output logic [WIDTH-1:0] resultVal,
  output logic [WIDTH-1:0] trialCode,
  output logic             lastBit
);
  localparam logic [WIDTH-1:0] MSB_MASK = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] resultQ, maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      maskQ   <= '0;
    end else if (strb.clearAll) begin
      resultQ <= '0;
      maskQ   <= '0;
    end else if (strb.beginSearch) begin
      maskQ <= MSB_MASK;
    end else if (strb.decideBit) begin
      if (cmpIn) resultQ <= resultQ | maskQ;
      maskQ <= maskQ >> 1;
    end
  end

  assign resultVal = resultQ;
  assign trialCode = resultQ | maskQ;
  assign lastBit   = maskQ[0];

  // R2
  clear_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (resultQ == '0 && maskQ == '0));

  // R5
  one_trial_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(maskQ));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clearAll && !strb.decideBit) |=> $stable(resultQ));
endmodule

// File: rtl/sarSequencer.sv
module sarSequencer
  import sarSeqPkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int BIT_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             cmpIn,
  input  logic             dataEnN,
  output logic [WIDTH-1:0] trialCode,
  output logic             busyOut,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataOe
);
  sarStrobes_t strb;
  logic lastBit;
  logic [WIDTH-1:0] resultVal;

  sarControl #(.BIT_CYCLES(BIT_CYCLES)) ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .lastBit(lastBit),
    .strb(strb), .busyOut(busyOut)
  );

  sarDatapath #(.WIDTH(WIDTH)) dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpIn(cmpIn),
    .resultVal(resultVal), .trialCode(trialCode), .lastBit(lastBit)
  );

  assign dataOe  = !dataEnN;
  assign dataOut = resultVal;
endmodule

// File: tb/sarSequencer_test.sv
module sarSequencer_test;
  localparam int BITC = 2;
  localparam int NBITS = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic dataEnN = 1'b1;
  logic bipolar = 1'b0;
  int   level = 0;
  logic cmpIn;
  logic [7:0] trialCode, dataOut;
  logic busyOut, dataOe;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  // comparator model: input level against DAC trial level
  assign cmpIn = bipolar ? (level >= int'(trialCode) - 128) : (level >= int'(trialCode));

  sarSequencer #(.WIDTH(8), .BIT_CYCLES(BITC)) uut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .cmpIn(cmpIn), .dataEnN(dataEnN),
    .trialCode(trialCode), .busyOut(busyOut), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readResult(string req, int exp);
    dataEnN = 1'b0;
    #1;
    check({req, " oe"}, int'(dataOe), 1);
    check({req, " data"}, int'(dataOut), exp);
    dataEnN = 1'b1;
    #1;
    check({req, " oe off"}, int'(dataOe), 0);
  endtask

  // rising edge, hold high for holdCyc negedges, then drop start
  task automatic armStart(int holdCyc);
    @(negedge clk); startIn = 1'b1;
    @(negedge clk);
    check("R2 busy after rise", int'(busyOut), 1);
    readResult("R2 cleared", 0);
    for (int i = 1; i < holdCyc; i++) begin
      @(negedge clk);
      check("R3 no trial while high", int'(trialCode), 0);
      check("R3 busy while high", int'(busyOut), 1);
    end
    startIn = 1'b0;
  endtask

  task automatic runConv(string req, int lvl, bit bip, int exp);
    level = lvl; bipolar = bip;
    armStart(3);
    @(negedge clk);
    check("R4 msb first", int'(trialCode), 8'h80);
    repeat (NBITS*BITC - 1) @(negedge clk);
    check("R6 busy before last", int'(busyOut), 1);
    @(negedge clk);
    check("R6 busy low", int'(busyOut), 0);
    readResult(req, exp);
  endtask

  task automatic testReset();
    #1;
    check("R1 busy", int'(busyOut), 0);
    check("R1 trial", int'(trialCode), 0);
    check("R1 data", int'(dataOut), 0);
    check("R1 oe", int'(dataOe), 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testBitTiming();
    level = 8'h10; bipolar = 1'b0;
    armStart(2);
    repeat (BITC) @(negedge clk);
    check("R5 still msb", int'(trialCode), 8'h80);
    @(negedge clk);
    check("R5 msb dropped", int'(trialCode), 8'h40);
    repeat (BITC) @(negedge clk);
    check("R5 bit6 dropped", int'(trialCode), 8'h20);
    repeat (NBITS*BITC) @(negedge clk);
    readResult("R5 final", 8'h10);
  endtask

  task automatic testPartial();
    level = 8'hA5; bipolar = 1'b0;
    armStart(2);
    repeat (4*BITC + 1) @(negedge clk);
    check("R8 busy mid", int'(busyOut), 1);
    readResult("R8 partial", 8'hA0);
    repeat (4*BITC) @(negedge clk);
    readResult("R8 final", 8'hA5);
  endtask

  task automatic testAbort();
    level = 8'h33; bipolar = 1'b0;
    armStart(2);
    repeat (3*BITC + 1) @(negedge clk);
    level = 8'hC8;
    armStart(2);
    @(negedge clk);
    check("R9 restart msb", int'(trialCode), 8'h80);
    repeat (NBITS*BITC - 1) @(negedge clk);
    check("R9 busy", int'(busyOut), 1);
    @(negedge clk);
    check("R9 done", int'(busyOut), 0);
    readResult("R9 fresh result", 8'hC8);
  endtask

  task automatic testHold();
    level = 8'h0F;
    repeat (20) @(negedge clk);
    check("R10 idle", int'(busyOut), 0);
    readResult("R10 held", 8'hC8);
  endtask

  initial begin
    testReset();
    runConv("R6 zero", 0, 1'b0, 8'h00);
    runConv("R6 full", 255, 1'b0, 8'hFF);
    runConv("R6 mid", 128, 1'b0, 8'h80);
    runConv("R6 a5", 8'hA5, 1'b0, 8'hA5);
    runConv("R6 5a", 8'h5A, 1'b0, 8'h5A);
    testBitTiming();
    testPartial();
    testAbort();
    testHold();
    runConv("R11 neg end", -128, 1'b1, 8'h00);
    runConv("R11 zero", 0, 1'b1, 8'h80);
    runConv("R11 minus one", -1, 1'b1, 8'h7F);
    readResult("R7 reread", 8'h7F);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule